// File: doc/BRIEF.md
# Dual-Rate Timebase with Deferred Chip-Enable Reset

The block turns a one-clock millisecond strobe into two periodic square waves. The first, the flag wave, sets a sticky carry bit that software polls and clears. The second, the interrupt wave, raises a one-clock interrupt request. Each wave takes its own 2-bit rate code. Both waves are derived from one free-running tick count that wraps every 1000 ticks, so their phases never drift against each other.

A rising edge on the chip-enable input does not reset the system straight away. It is held as a pending request and released as a one-clock reset strobe at the next start of a flag period. At the two slow rates the interrupt wave is shifted in phase, so that it ends a set number of ticks (LEAD_TICKS) before a flag period starts. Interrupt servicing that finishes inside that window therefore completes before the deferred reset arrives, and no interrupt is lost.

Top module: `dual_rate_timebase`

## Requirements
- R1: Rate codes map to periods in ticks as follows: 00 = 250, 01 = 100, 10 = 5, 11 = 1. The tick count runs from reset modulo 1000, and a flag period starts at every count that is a multiple of the period. `flag_pulse` is high for the first max(P/2,1) ticks of each period. It updates on the clock edge that samples `tick_ms`.
- R2: At rate codes 00 and 01, `irq_pulse` has the same high length as R1. Its falling edge comes at the tick where the count plus LEAD_TICKS (default 10) is a multiple of the period. With equal slow codes on both waves, the interrupt wave therefore falls exactly LEAD_TICKS ticks before each flag rise.
- R3: At rate codes 10 and 11, `irq_pulse` has no phase shift and has the same shape as the flag wave at that code.
- R4: `carry_flag` goes high on the clock edge after a tick that starts a flag period. It then stays high across later ticks until it is cleared.
- R5: A `carry_clr` pulse clears `carry_flag` on the next edge. If the clear and a flag-period start land on the same edge, the flag stays set.
- R6: `irq_req` is high for exactly one clock, on the edge after a tick that starts an interrupt high phase, and only while `irq_en` is 1. With `irq_en` at 0 no request appears.
- R7: A rising edge on `ce_in` is latched as pending. `ce_reset` pulses for one clock on the edge after the next tick that starts a flag period, and that pulse clears the pending request. Holding `ce_in` high does not trigger again.
- R8: A `ce_in` rising edge that is sampled on the same edge as a flag-period start is not served by that start. It is deferred to the following one.
- R9: After reset, `carry_flag`, `irq_req` and `ce_reset` are 0 and the tick count is 0. `flag_pulse` is therefore high and, at code 00, `irq_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-clock strobe, once per millisecond |
| flag_rate | input | 2 | Rate code of the flag wave |
| irq_rate | input | 2 | Rate code of the interrupt wave |
| irq_en | input | 1 | Gates interrupt requests |
| carry_clr | input | 1 | Read-and-clear strobe for the carry flag |
| ce_in | input | 1 | Chip-enable input; a rising edge requests reset |
| flag_pulse | output | 1 | Flag square wave |
| irq_pulse | output | 1 | Interrupt square wave |
| carry_flag | output | 1 | Sticky carry flag |
| irq_req | output | 1 | One-clock interrupt request |
| ce_reset | output | 1 | One-clock deferred reset strobe |

## Verification
The assertions assume that `tick_ms` is never high on two consecutive clocks. The one-clock checks on `irq_req` and `ce_reset` depend on this, because at the 1 kHz code every tick starts a period. The bench always drives the strobe with at least three idle clocks between ticks. It changes rate codes, `ce_in` and `carry_clr` only at falling clock edges. It keeps `ce_in` low through reset, so that no request is pending when reset is released.

// File: rtl/drtb_pkg.sv
package drtb_pkg;
   localparam int unsigned NUM_RATES = 4;

   typedef enum logic [1:0] {
      RATE_4HZ   = 2'b00,
      RATE_10HZ  = 2'b01,
      RATE_200HZ = 2'b10,
      RATE_1KHZ  = 2'b11
   } rate_e;
endpackage

// File: rtl/drtb_phase_bank.sv
module drtb_phase_bank
   import drtb_pkg::*;
#(
   parameter int unsigned CW     = 10,
   parameter int unsigned WRAP   = 1000,
   parameter int unsigned T0     = 250,
   parameter int unsigned T1     = 100,
   parameter int unsigned T2     = 5,
   parameter int unsigned T3     = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick_ms,
   output logic [NUM_RATES-1:0][CW-1:0]  phase,
   output logic                          tick_seen
);
   logic [CW-1:0] wrap_cnt;
   logic          wrap_now;

   assign wrap_now = tick_ms && (wrap_cnt == CW'(WRAP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wrap_cnt  <= '0;
         tick_seen <= 1'b0;
      end else begin
         tick_seen <= tick_ms;
         if (tick_ms) wrap_cnt <= wrap_now ? '0 : wrap_cnt + CW'(1);
      end
   end

   // one modulo counter per rate code, re-aligned at every wrap of the base count
   generate
      for (genvar g = 0; g < NUM_RATES; g++) begin : g_phase
         localparam int unsigned PER = (g == 0) ? T0 : (g == 1) ? T1 : (g == 2) ? T2 : T3;
         logic [CW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ph_q <= '0;
            else if (tick_ms) ph_q <= (wrap_now || ph_q == CW'(PER - 1)) ? '0 : ph_q + CW'(1);
         end
         assign phase[g] = ph_q;
      end
   endgenerate
endmodule

// File: rtl/drtb_pulse_gen.sv
module drtb_pulse_gen
   import drtb_pkg::*;
#(
   parameter int unsigned CW         = 10,
   parameter int unsigned T0         = 250,
   parameter int unsigned T1         = 100,
   parameter int unsigned T2         = 5,
   parameter int unsigned T3         = 1,
   parameter int unsigned LEAD       = 10,
   parameter bit          SHIFT_SLOW = 1'b0
) (
   input  logic [NUM_RATES-1:0][CW-1:0] phase,
   input  logic [1:0]                   rate,
   input  logic                         tick_seen,
   output logic                         level,
   output logic                         rise
);
   localparam int unsigned H0 = (T0 / 2 == 0) ? 1 : T0 / 2;
   localparam int unsigned H1 = (T1 / 2 == 0) ? 1 : T1 / 2;
   localparam int unsigned H2 = (T2 / 2 == 0) ? 1 : T2 / 2;
   localparam int unsigned H3 = (T3 / 2 == 0) ? 1 : T3 / 2;

   rate_e         rsel;
   logic [CW-1:0] per, half, ph, add, pos;
   logic [CW:0]   sum;

   assign rsel = rate_e'(rate);
   assign ph   = phase[rate];

   always_comb begin
      unique case (rsel)
         RATE_4HZ:   begin per = CW'(T0); half = CW'(H0); end
         RATE_10HZ:  begin per = CW'(T1); half = CW'(H1); end
         RATE_200HZ: begin per = CW'(T2); half = CW'(H2); end
         default:    begin per = CW'(T3); half = CW'(H3); end
      endcase
   end

   generate
      if (SHIFT_SLOW) begin : g_shift
         // slow codes: advance the wave so it ends LEAD ticks before the period boundary
         assign add = (rsel == RATE_4HZ || rsel == RATE_10HZ) ? half + CW'(LEAD) : '0;
      end else begin : g_plain
         assign add = '0;
      end
   endgenerate

   assign sum   = {1'b0, ph} + {1'b0, add};
   assign pos   = (sum >= {1'b0, per}) ? CW'(sum - {1'b0, per}) : sum[CW-1:0];
   assign level = (pos < half);
   assign rise  = tick_seen && (pos == '0);
endmodule

// File: rtl/drtb_ctrl.sv
module drtb_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_rise,
   input  logic irq_rise,
   input  logic irq_en,
   input  logic carry_clr,
   input  logic ce_in,
   output logic carry_flag,
   output logic irq_req,
   output logic ce_reset
);
   logic ce_q, ce_edge, ce_pend;

   assign ce_edge = ce_in && !ce_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q       <= 1'b0;
         ce_pend    <= 1'b0;
         ce_reset   <= 1'b0;
         carry_flag <= 1'b0;
         irq_req    <= 1'b0;
      end else begin
         ce_q       <= ce_in;
         // a fresh edge stays pending even if it meets a flag start
         ce_pend    <= ce_edge || (ce_pend && !flag_rise);
         ce_reset   <= flag_rise && ce_pend;
         carry_flag <= flag_rise || (carry_flag && !carry_clr);
         irq_req    <= irq_rise && irq_en;
      end
   end
endmodule

// File: rtl/dual_rate_timebase.sv
module dual_rate_timebase
   import drtb_pkg::*;
#(
   parameter int unsigned WRAP_TICKS  = 1000,
   parameter int unsigned LEAD_TICKS  = 10,
   parameter int unsigned TICKS_CODE0 = 250,
   parameter int unsigned TICKS_CODE1 = 100,
   parameter int unsigned TICKS_CODE2 = 5,
   parameter int unsigned TICKS_CODE3 = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic [1:0] flag_rate,
   input  logic [1:0] irq_rate,
   input  logic       irq_en,
   input  logic       carry_clr,
   input  logic       ce_in,
   output logic       flag_pulse,
   output logic       irq_pulse,
   output logic       carry_flag,
   output logic       irq_req,
   output logic       ce_reset
);
   localparam int unsigned CW = $clog2(WRAP_TICKS);

   generate
      if ((WRAP_TICKS % TICKS_CODE0) != 0 || (WRAP_TICKS % TICKS_CODE1) != 0 ||
          (WRAP_TICKS % TICKS_CODE2) != 0 || (WRAP_TICKS % TICKS_CODE3) != 0) begin : g_bad_period
         $error("every period must divide WRAP_TICKS");
      end
      if (2 * LEAD_TICKS >= TICKS_CODE0 || 2 * LEAD_TICKS >= TICKS_CODE1) begin : g_bad_lead
         $error("LEAD_TICKS must be below half of each slow period");
      end
   endgenerate

   logic [NUM_RATES-1:0][CW-1:0] phase;
   logic tick_seen, flag_rise, irq_rise;

   drtb_phase_bank #(
      .CW(CW), .WRAP(WRAP_TICKS),
      .T0(TICKS_CODE0), .T1(TICKS_CODE1), .T2(TICKS_CODE2), .T3(TICKS_CODE3)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .phase(phase), .tick_seen(tick_seen)
   );

   drtb_pulse_gen #(
      .CW(CW), .T0(TICKS_CODE0), .T1(TICKS_CODE1), .T2(TICKS_CODE2), .T3(TICKS_CODE3),
      .LEAD(LEAD_TICKS), .SHIFT_SLOW(1'b0)
   ) u_flag_gen (
      .phase(phase), .rate(flag_rate), .tick_seen(tick_seen), .level(flag_pulse), .rise(flag_rise)
   );

   drtb_pulse_gen #(
      .CW(CW), .T0(TICKS_CODE0), .T1(TICKS_CODE1), .T2(TICKS_CODE2), .T3(TICKS_CODE3),
      .LEAD(LEAD_TICKS), .SHIFT_SLOW(1'b1)
   ) u_irq_gen (
      .phase(phase), .rate(irq_rate), .tick_seen(tick_seen), .level(irq_pulse), .rise(irq_rise)
   );

   drtb_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .flag_rise(flag_rise), .irq_rise(irq_rise),
      .irq_en(irq_en), .carry_clr(carry_clr), .ce_in(ce_in),
      .carry_flag(carry_flag), .irq_req(irq_req), .ce_reset(ce_reset)
   );
endmodule

// File: rtl/drtb_checker.sv
module drtb_checker (
   input logic clk,
   input logic rst_n,
   input logic tick_ms,
   input logic irq_en,
   input logic carry_clr,
   input logic carry_flag,
   input logic irq_req,
   input logic ce_reset,
   input logic flag_rise,
   input logic irq_rise
);
   // input assumption: the millisecond strobe never lasts two clocks
   assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick_ms |=> !tick_ms);

   assert_irq_req_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(irq_rise && irq_en));

   assert_irq_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);

   assert_carry_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_flag && !carry_clr) |=> carry_flag);

   assert_carry_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flag_rise |=> carry_flag);

   assert_carry_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_clr && !flag_rise) |=> !carry_flag);

   assert_ce_on_flag_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ce_reset |-> $past(flag_rise));

   assert_ce_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ce_reset |=> !ce_reset);
endmodule

bind dual_rate_timebase drtb_checker u_chk (
   .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .irq_en(irq_en), .carry_clr(carry_clr),
   .carry_flag(carry_flag), .irq_req(irq_req), .ce_reset(ce_reset),
   .flag_rise(flag_rise), .irq_rise(irq_rise)
);

// File: tb/dual_rate_timebase_bench.sv
`timescale 1ns/1ps
module dual_rate_timebase_bench;
   localparam int LEAD = 10;

   logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, irq_en = 1'b1, carry_clr = 1'b0, ce_in = 1'b0;
   logic [1:0] flag_rate = 2'b00, irq_rate = 2'b00;
   logic flag_pulse, irq_pulse, carry_flag, irq_req, ce_reset;

   int vectors = 0, fails = 0, cnt = 0, tickno = 0;
   bit done = 1'b0;
   logic s_flag, s_irq, s_req, s_req2, s_rst, s_rst2, s_carry;

   always #2.5 clk = ~clk;

   dual_rate_timebase u_dual_rate_timebase (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .flag_rate(flag_rate), .irq_rate(irq_rate),
      .irq_en(irq_en), .carry_clr(carry_clr), .ce_in(ce_in), .flag_pulse(flag_pulse),
      .irq_pulse(irq_pulse), .carry_flag(carry_flag), .irq_req(irq_req), .ce_reset(ce_reset)
   );

   task automatic check(input string req, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s tick %0d: got %0d expected %0d", req, tickno, got, exp);
      end
   endtask

   function automatic int per_of(input int code);
      case (code)
         0: return 250;
         1: return 100;
         2: return 5;
         default: return 1;
      endcase
   endfunction

   function automatic int half_of(input int p);
      return (p / 2 == 0) ? 1 : p / 2;
   endfunction

   function automatic int pos_of(input int code, input int c, input bit shift);
      int p = per_of(code);
      int ph = c % p;
      if (shift && code < 2) ph = (ph + half_of(p) + LEAD) % p;
      return ph;
   endfunction

   function automatic bit exp_lvl(input int code, input bit shift);
      return pos_of(code, cnt, shift) < half_of(per_of(code));
   endfunction

   function automatic bit exp_rise(input int code, input bit shift);
      return pos_of(code, cnt, shift) == 0;
   endfunction

   // one tick; optional clear and chip-enable edge in the cycle after the sampling edge
   task automatic do_tick(input bit clr_co, input bit ce_co);
      @(negedge clk); tick_ms = 1'b1;
      @(negedge clk); tick_ms = 1'b0; carry_clr = clr_co; if (ce_co) ce_in = 1'b1;
      cnt = (cnt + 1) % 1000; tickno++;
      s_flag = flag_pulse; s_irq = irq_pulse;
      @(negedge clk); carry_clr = 1'b0;
      s_req = irq_req; s_rst = ce_reset; s_carry = carry_flag;
      @(negedge clk);
      s_req2 = irq_req; s_rst2 = ce_reset;
   endtask

   task automatic clear_pulse();
      @(negedge clk); carry_clr = 1'b1;
      @(negedge clk); carry_clr = 1'b0;
   endtask

   task automatic test_reset();
      check("R9 flag_pulse", flag_pulse, 1);
      check("R9 irq_pulse", irq_pulse, 0);
      check("R9 carry_flag", carry_flag, 0);
      check("R9 irq_req", irq_req, 0);
      check("R9 ce_reset", ce_reset, 0);
   endtask

   task automatic run_rates(input int fc, input int ic, input int n);
      int last_fall = -100000;
      logic pf, pi;
      @(negedge clk); flag_rate = 2'(fc); irq_rate = 2'(ic); irq_en = 1'b1;
      @(negedge clk); pf = flag_pulse; pi = irq_pulse;
      for (int k = 0; k < n; k++) begin
         do_tick(1'b0, 1'b0);
         check("R1 flag level", s_flag, exp_lvl(fc, 1'b0));
         check(ic < 2 ? "R2 irq level" : "R3 irq level", s_irq, exp_lvl(ic, 1'b1));
         check("R6 irq_req", s_req, exp_rise(ic, 1'b1));
         check("R6 irq_req one clock", s_req2, 0);
         if (pi && !s_irq) last_fall = tickno;
         if (!pf && s_flag && fc == ic && fc < 2)
            check("R2 lead before flag rise", tickno - last_fall, LEAD);
         pf = s_flag; pi = s_irq;
      end
   endtask

   task automatic test_carry();
      @(negedge clk); flag_rate = 2'b10;
      clear_pulse();
      check("R5 clear", carry_flag, 0);
      do_tick(1'b0, 1'b0);
      while (!exp_rise(2, 1'b0)) begin
         check("R4 no set off-edge", s_carry, 0);
         do_tick(1'b0, 1'b0);
      end
      check("R4 set on flag start", s_carry, 1);
      do_tick(1'b0, 1'b0);
      check("R4 sticky", s_carry, 1);
      do_tick(1'b0, 1'b0);
      check("R4 sticky", s_carry, 1);
      clear_pulse();
      check("R5 clear", carry_flag, 0);
      do_tick(1'b0, 1'b0);
      while (!exp_rise(2, 1'b0)) do_tick(1'b0, 1'b0);
      clear_pulse();
      while (cnt % 5 != 4) do_tick(1'b0, 1'b0);
      do_tick(1'b1, 1'b0);
      check("R5 set wins over clear", s_carry, 1);
      clear_pulse();
   endtask

   task automatic test_irq_gate();
      @(negedge clk); irq_rate = 2'b11; irq_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         do_tick(1'b0, 1'b0);
         check("R6 gated off", s_req, 0);
      end
      @(negedge clk); irq_en = 1'b1;
      do_tick(1'b0, 1'b0);
      check("R6 enabled", s_req, 1);
   endtask

   task automatic test_ce();
      @(negedge clk); flag_rate = 2'b10; ce_in = 1'b0;
      while (cnt % 5 != 2) do_tick(1'b0, 1'b0);
      @(negedge clk); ce_in = 1'b1;
      do_tick(1'b0, 1'b0);
      while (!exp_rise(2, 1'b0)) begin
         check("R7 held until flag start", s_rst, 0);
         do_tick(1'b0, 1'b0);
      end
      check("R7 reset at flag start", s_rst, 1);
      check("R7 one clock", s_rst2, 0);
      do_tick(1'b0, 1'b0);
      while (!exp_rise(2, 1'b0)) do_tick(1'b0, 1'b0);
      check("R7 level does not retrigger", s_rst, 0);
      @(negedge clk); ce_in = 1'b0;
      while (cnt % 5 != 4) do_tick(1'b0, 1'b0);
      do_tick(1'b0, 1'b1);
      check("R8 coincident edge not served", s_rst, 0);
      do_tick(1'b0, 1'b0);
      while (!exp_rise(2, 1'b0)) begin
         check("R8 still pending", s_rst, 0);
         do_tick(1'b0, 1'b0);
      end
      check("R8 served at following start", s_rst, 1);
      @(negedge clk); ce_in = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      run_rates(0, 0, 1000);
      run_rates(1, 1, 1000);
      run_rates(2, 2, 20);
      run_rates(3, 3, 10);
      run_rates(0, 2, 500);
      run_rates(3, 1, 300);
      test_carry();
      test_irq_gate();
      test_ce();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule